// File: doc/BRIEF.md
# Hypervisor-Aware Local Interrupt Selector

This block decides which local interrupt a hart should take next. It combines the raw pending and enable vectors, the machine delegation vector, the current privilege level, a virtualization-mode flag and three global interrupt-enable bits. The enable bits are machine, supervisor, and the host-supervisor copy kept while a guest runs. Its result is registered: a valid flag, the cause index of the chosen interrupt, and a flag that tells trap logic to enter the host supervisor instead of the guest.

Three enabled pending bits belong to the guest supervisor: software at bit 2, timer at bit 6 and external at bit 10. Outside virtualization they are never chosen. While a guest runs, the selector first looks for any other enabled pending interrupt that the host-supervisor gate lets through. If one is found, that interrupt wins and the force flag is raised. Otherwise the guest bits are moved down one position onto the supervisor slots 1, 5 and 9. Delegation and the machine and supervisor gates then apply to them as if they were ordinary interrupts. Among the surviving candidates, the lowest-numbered bit is chosen.

Top module: `hvirq_select`

## Requirements
- R1: The base candidate vector is the bitwise AND of the pending and enable inputs, with bits 2, 6 and 10 cleared. Outside virtualization mode, those three bits can never be selected, whatever their pending or enable state.
- R2: In virtualization mode, when the host-priority path (R6) does not fire, only enabled pending bits 2, 6 and 10 are candidates. They are considered at positions 1, 5 and 9 respectively, and delegation and gating use those new positions.
- R3: The privilege input is encoded as user 0, supervisor 1 and machine 3. The machine gate is open when privilege is below 3, or when it equals 3 and the machine enable bit is set.
- R4: The supervisor gate is open when privilege is below 1, or when it equals 1 and the supervisor enable bit is set.
- R5: The host-supervisor gate follows the rule of R4 but reads the host-side enable bit instead of the supervisor enable bit.
- R6: In virtualization mode, if the host-supervisor gate is open and the base vector of R1 is non-zero, the lowest set bit of the base vector is reported with the force flag high. No delegation or other gate applies in that case.
- R7: On the normal path, a candidate whose delegation bit is 0 passes only through the machine gate. A candidate whose delegation bit is 1 passes only through the supervisor gate.
- R8: When several candidates survive, the cause output is the index of the lowest-numbered one.
- R9: With no surviving candidate, the valid output is low. The force flag is low whenever the host-priority path does not fire.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high reset drives valid, cause and force to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| privLvl | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virtOn | input | 1 | Hart is running a guest |
| mStatIe | input | 1 | Machine global interrupt enable |
| sStatIe | input | 1 | Supervisor global interrupt enable |
| hsStatIe | input | 1 | Host-side saved supervisor interrupt enable |
| irqPend | input | 64 | Pending interrupt bits |
| irqEn | input | 64 | Interrupt enable bits |
| irqDeleg | input | 64 | Machine delegation bits |
| takeValid | output | 1 | An interrupt is selected |
| takeCause | output | 6 | Index of the selected interrupt |
| takeForceHs | output | 1 | Selection came from the host-priority path |

## Verification
Directed cases isolate one rule at a time:
- A lone guest bit outside virtualization tells apart masking (R1) from a missing mask.
- A lone guest bit inside virtualization tells apart the remap (R2) from a pass-through.
- Delegated and undelegated candidates under each privilege level and enable setting tell apart the machine and supervisor gates (R3, R4, R7).
- A host and a guest interrupt pending together tell apart host priority from guest selection (R5, R6).
- Two simultaneous candidates show whether the lowest index wins (R8).

Random vectors with sparse bit densities, all four privilege codes and random enable, delegation and virtualization settings are then compared each cycle with a bench reference model. A reset asserted while candidates are pending shows that reset overrides the selection (R10).

// File: rtl/hvirq_pkg.sv
package hvirq_pkg;

  localparam int unsigned IRQ_W_DEF = 64;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic mGate;     // machine-level global gate open
    logic sGate;     // supervisor-level global gate open
    logic hsGate;    // host-supervisor gate open
    logic useGuest;  // select remapped guest vector
    logic forceHs;   // host-priority path taken
  } selStrobe_t;

endpackage

// File: rtl/hvirq_lsb_find.sv
module hvirq_lsb_find #(
  parameter int unsigned VEC_W = 64,
  localparam int unsigned IDX_W = (VEC_W > 1) ? $clog2(VEC_W) : 1
) (
  input  logic [VEC_W-1:0] vecIn,
  output logic             anySet,
  output logic [IDX_W-1:0] lowIdx
);

  always_comb begin
    lowIdx = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (vecIn[i]) lowIdx = IDX_W'(i);
    end
  end

  assign anySet = |vecIn;

endmodule

// File: rtl/hvirq_ctrl.sv
module hvirq_ctrl
  import hvirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] privLvl,
  input  logic       virtOn,
  input  logic       mStatIe,
  input  logic       sStatIe,
  input  logic       hsStatIe,
  input  logic       baseAny,
  output selStrobe_t stb
);

  // Gate open below the level, or at the level with its enable set.
  function automatic logic levelGate(input logic [1:0] cur, input priv_e lvl, input logic ie);
    return (cur < 2'(lvl)) || ((cur == 2'(lvl)) && ie);
  endfunction

  logic mGateW, sGateW, hsGateW, hostHit;

  always_comb begin
    mGateW  = levelGate(privLvl, PRIV_M, mStatIe);
    sGateW  = levelGate(privLvl, PRIV_S, sStatIe);
    hsGateW = levelGate(privLvl, PRIV_S, hsStatIe);
    hostHit = virtOn && hsGateW && baseAny;
  end

  always_comb begin
    stb.mGate    = mGateW;
    stb.sGate    = sGateW;
    stb.hsGate   = hsGateW;
    stb.forceHs  = hostHit;
    stb.useGuest = virtOn && !hostHit;
  end

  assert_plain_no_virt_paths_R9: assert property (@(posedge clk) disable iff (rst)
    !virtOn |-> (!stb.forceHs && !stb.useGuest));

  assert_user_gates_open_R3: assert property (@(posedge clk) disable iff (rst)
    (privLvl == 2'(PRIV_U)) |-> (stb.mGate && stb.sGate && stb.hsGate));

  assert_machine_closes_super_R4: assert property (@(posedge clk) disable iff (rst)
    (privLvl == 2'(PRIV_M)) |-> (!stb.sGate && !stb.hsGate));

endmodule

// File: rtl/hvirq_datapath.sv
module hvirq_datapath
  import hvirq_pkg::*;
#(
  parameter int unsigned           IRQ_W   = 64,
  parameter logic [IRQ_W-1:0]      VS_MASK = 'h444,
  localparam int unsigned          CAUSE_W = $clog2(IRQ_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IRQ_W-1:0]   irqPend,
  input  logic [IRQ_W-1:0]   irqEn,
  input  logic [IRQ_W-1:0]   irqDeleg,
  input  selStrobe_t         stb,
  output logic               baseAny,
  output logic               takeValid,
  output logic [CAUSE_W-1:0] takeCause,
  output logic               takeForceHs
);

  localparam logic [IRQ_W-1:0] GUEST_SLOTS = VS_MASK >> 1;

  logic [IRQ_W-1:0] armedVec, baseVec, guestVec, selVec, finalVec, pickVec;
  logic             pickAny;
  logic [CAUSE_W-1:0] pickIdx;

  always_comb begin
    armedVec = irqPend & irqEn;
    baseVec  = armedVec & ~VS_MASK;
    guestVec = (armedVec & VS_MASK) >> 1;
    selVec   = stb.useGuest ? guestVec : baseVec;
    finalVec = (selVec & ~irqDeleg & {IRQ_W{stb.mGate}})
             | (selVec &  irqDeleg & {IRQ_W{stb.sGate}});
    pickVec  = stb.forceHs ? baseVec : finalVec;
  end

  assign baseAny = |baseVec;

  hvirq_lsb_find #(.VEC_W(IRQ_W)) lsb_i (
    .vecIn  (pickVec),
    .anySet (pickAny),
    .lowIdx (pickIdx)
  );

  logic               validQ, forceQ;
  logic [CAUSE_W-1:0] causeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
      forceQ <= 1'b0;
      causeQ <= '0;
    end else begin
      validQ <= pickAny;
      forceQ <= stb.forceHs;
      causeQ <= pickIdx;
    end
  end

  assign takeValid   = validQ;
  assign takeForceHs = forceQ;
  assign takeCause   = causeQ;

  assert_force_implies_valid_R6: assert property (@(posedge clk) disable iff (rst)
    forceQ |-> validQ);

  assert_cause_bit_set_R8: assert property (@(posedge clk) disable iff (rst)
    validQ |-> ((($past(pickVec) >> causeQ) & IRQ_W'(1)) != '0));

  assert_cause_is_lowest_R8: assert property (@(posedge clk) disable iff (rst)
    validQ |-> (($past(pickVec) & ((IRQ_W'(1) << causeQ) - IRQ_W'(1))) == '0));

  assert_guest_slots_only_R2: assert property (@(posedge clk) disable iff (rst)
    stb.useGuest |-> ((pickVec & ~GUEST_SLOTS) == '0));

  assert_guest_bits_masked_R1: assert property (@(posedge clk) disable iff (rst)
    !stb.useGuest |-> ((pickVec & VS_MASK) == '0));

endmodule

// File: rtl/hvirq_select.sv
module hvirq_select
  import hvirq_pkg::*;
#(
  parameter int unsigned      IRQ_W   = IRQ_W_DEF,
  parameter logic [IRQ_W-1:0] VS_MASK = 'h444,
  localparam int unsigned     CAUSE_W = $clog2(IRQ_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         privLvl,
  input  logic               virtOn,
  input  logic               mStatIe,
  input  logic               sStatIe,
  input  logic               hsStatIe,
  input  logic [IRQ_W-1:0]   irqPend,
  input  logic [IRQ_W-1:0]   irqEn,
  input  logic [IRQ_W-1:0]   irqDeleg,
  output logic               takeValid,
  output logic [CAUSE_W-1:0] takeCause,
  output logic               takeForceHs
);

  selStrobe_t stb;
  logic       baseAny;

  hvirq_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .privLvl  (privLvl),
    .virtOn   (virtOn),
    .mStatIe  (mStatIe),
    .sStatIe  (sStatIe),
    .hsStatIe (hsStatIe),
    .baseAny  (baseAny),
    .stb      (stb)
  );

  hvirq_datapath #(.IRQ_W(IRQ_W), .VS_MASK(VS_MASK)) dp_i (
    .clk         (clk),
    .rst         (rst),
    .irqPend     (irqPend),
    .irqEn       (irqEn),
    .irqDeleg    (irqDeleg),
    .stb         (stb),
    .baseAny     (baseAny),
    .takeValid   (takeValid),
    .takeCause   (takeCause),
    .takeForceHs (takeForceHs)
  );

endmodule

// File: tb/hvirq_select_tb_top.sv
`timescale 1ns/1ps
module hvirq_select_tb_top;

  typedef struct packed {
    logic       v;
    logic       f;
    logic [5:0] c;
  } exp_t;

  localparam logic [63:0] GUEST_BITS = 64'h0000_0000_0000_0444;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  privLvl = 2'd0;
  logic        virtOn = 1'b0, mStatIe = 1'b0, sStatIe = 1'b0, hsStatIe = 1'b0;
  logic [63:0] irqPend = '0, irqEn = '0, irqDeleg = '0;
  logic        takeValid, takeForceHs;
  logic [5:0]  takeCause;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  hvirq_select dut_i (
    .clk(clk), .rst(rst), .privLvl(privLvl), .virtOn(virtOn),
    .mStatIe(mStatIe), .sStatIe(sStatIe), .hsStatIe(hsStatIe),
    .irqPend(irqPend), .irqEn(irqEn), .irqDeleg(irqDeleg),
    .takeValid(takeValid), .takeCause(takeCause), .takeForceHs(takeForceHs)
  );

  function automatic logic [5:0] lowBit(input logic [63:0] v);
    logic [5:0] r = '0;
    for (int i = 63; i >= 0; i--) if (v[i]) r = 6'(i);
    return r;
  endfunction

  function automatic exp_t refModel();
    exp_t e;
    logic mG, sG, hG;
    logic [63:0] base, guest, vec, cand;
    mG = (privLvl < 2'd3) || (privLvl == 2'd3 && mStatIe);
    sG = (privLvl < 2'd1) || (privLvl == 2'd1 && sStatIe);
    hG = (privLvl < 2'd1) || (privLvl == 2'd1 && hsStatIe);
    base  = irqPend & irqEn & ~GUEST_BITS;
    guest = (irqPend & irqEn & GUEST_BITS) >> 1;
    if (virtOn && hG && base != 0) begin
      e.v = 1'b1; e.f = 1'b1; e.c = lowBit(base);
    end else begin
      vec  = virtOn ? guest : base;
      cand = (vec & ~irqDeleg & {64{mG}}) | (vec & irqDeleg & {64{sG}});
      e.f = 1'b0;
      e.v = (cand != 0);
      e.c = e.v ? lowBit(cand) : 6'd0;
    end
    return e;
  endfunction

  task automatic checkOut(input string req, input exp_t exp);
    exp_t act;
    act = '{v: takeValid, f: takeForceHs, c: takeCause};
    checkCount++;
    if (!exp.v) begin
      act.c = 6'd0;
      exp.c = 6'd0;
    end
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual valid=%0b force=%0b cause=%0d, expected valid=%0b force=%0b cause=%0d",
               req, act.v, act.f, act.c, exp.v, exp.f, exp.c);
    end
  endtask

  task automatic setIn(input logic [1:0] p, input logic vt, input logic m, input logic s,
                       input logic h, input logic [63:0] pe, input logic [63:0] en,
                       input logic [63:0] dl);
    privLvl = p; virtOn = vt; mStatIe = m; sStatIe = s; hsStatIe = h;
    irqPend = pe; irqEn = en; irqDeleg = dl;
  endtask

  // Drive at a falling edge; the next rising edge registers; check at the following falling edge.
  task automatic step(input string req, input logic [1:0] p, input logic vt, input logic m,
                      input logic s, input logic h, input logic [63:0] pe,
                      input logic [63:0] en, input logic [63:0] dl);
    exp_t e;
    @(negedge clk);
    setIn(p, vt, m, s, h, pe, en, dl);
    e = refModel();
    @(negedge clk);
    checkOut(req, e);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin : stimulus
    exp_t zero;
    void'($urandom(32'd1357));
    zero = '0;
    repeat (3) @(negedge clk);
    checkOut("R10 reset state", zero);
    rst = 1'b0;

    // R9: nothing pending
    step("R9 empty", 2'd0, 1'b0, 1, 1, 1, 64'h0, '1, 64'h0);
    // R1: guest bit alone outside virtualization is never chosen
    step("R1 guest bit masked", 2'd0, 1'b0, 1, 1, 1, 64'h4, 64'h4, 64'h0);
    step("R1 all guest bits masked", 2'd1, 1'b0, 1, 1, 1, GUEST_BITS, '1, '1);
    // R2: guest timer bit 6 appears as cause 5
    step("R2 guest remap", 2'd0, 1'b1, 1, 1, 0, 64'h40, '1, 64'h0);
    step("R2 guest remap delegated", 2'd1, 1'b1, 0, 1, 0, 64'h400, '1, '1);
    // R3: machine gate closed at machine level with enable low
    step("R3 machine gate closed", 2'd3, 1'b0, 0, 1, 1, 64'h80, '1, 64'h0);
    step("R3 machine gate open", 2'd3, 1'b0, 1, 0, 0, 64'h80, '1, 64'h0);
    // R4: supervisor gate
    step("R4 super gate closed", 2'd1, 1'b0, 1, 0, 1, 64'h20, '1, 64'h20);
    step("R4 super gate open", 2'd1, 1'b0, 0, 1, 0, 64'h20, '1, 64'h20);
    // R7: delegated interrupt at machine level never taken
    step("R7 delegated at machine", 2'd3, 1'b0, 1, 1, 1, 64'h20, '1, 64'h20);
    step("R7 undelegated at super", 2'd1, 1'b0, 0, 1, 1, 64'h800, '1, 64'h0);
    // R5 / R6: host priority over guest
    step("R6 host priority", 2'd1, 1'b1, 0, 1, 1, 64'h204, '1, '1);
    step("R5 host gate closed", 2'd1, 1'b1, 1, 1, 0, 64'h204, '1, 64'h0);
    step("R6 host at user", 2'd0, 1'b1, 0, 0, 0, 64'h1_0000, '1, 64'h0);
    // R8: lowest index wins
    step("R8 lowest of two", 2'd0, 1'b0, 1, 1, 1, 64'h88, '1, 64'h0);
    step("R8 top bit", 2'd0, 1'b0, 1, 1, 1, 64'h8000_0000_0000_0000, '1, 64'h0);

    // R10: reset overrides a pending selection
    @(negedge clk);
    setIn(2'd0, 1'b0, 1, 1, 1, 64'h2, '1, 64'h0);
    rst = 1'b1;
    @(negedge clk);
    checkOut("R10 reset overrides", zero);
    rst = 1'b0;

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] pe, en, dl;
      logic [1:0]  pr;
      pe = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if (n % 3 == 0) pe = pe & 64'hFFF;
      en = {$urandom, $urandom} | {$urandom, $urandom};
      dl = {$urandom, $urandom};
      pr = 2'($urandom_range(0, 3));
      step("R8 random vs model", pr, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), pe, en, dl);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule